// File: doc/BRIEF.md
# Streaming Transpose Permutation Unit

This block reorders a streamed vector of N = W·W words that arrives W words per cycle over W beats. It applies the stride permutation that sends input index i = a·W + b to output index b·W + a. Viewed as a W×W tile, the word that enters on beat t and lane p leaves on beat p and lane t. The block accepts a new word on every lane in every cycle, with no stall between vectors. Each completed vector comes out as a burst of W consecutive beats after a fixed delay.

The data path has three parts. An XOR crossbar first steers the W incoming words into W simple dual-port RAM banks, each W words deep, so the total storage is N words. The banks then reorder the words in time. A second XOR crossbar restores the lane order on the way out. Consecutive vectors alternate between two address maps, so a location can take a word of the next vector in the same cycle that the word of the previous vector is read from it. No second buffer is needed. With the default LOG_W = 2, the block handles 16-word vectors over 4 beats.

Top module: `stream_transpose_perm`

## Requirements
- R1: While `rst` is high, and after it is released until a complete vector has been accepted, `out_valid` is low.
- R2: Lane j of `in_data`/`out_data` is bits [j·DATA_W +: DATA_W]. The word on input beat t, lane p of a vector appears on output beat p, lane t of that vector.
- R3: When the final (W-th) accepted beat of a vector is sampled at clock edge E, output beat c of that vector is presented at edge E + 2 + c, for c = 0 … W-1.
- R4: Vectors may follow one another with `in_valid` held high continuously, without limit. Every vector is permuted correctly and output beats are continuous.
- R5: Cycles with `in_valid` low may occur anywhere, within a vector or between vectors. Those cycles, and the data presented during them, have no effect on any output word.
- R6: `out_valid` is high for exactly W consecutive cycles per accepted vector and is never high otherwise.
- R7: Asserting `rst` discards a partially accepted vector. The next accepted beat after reset is beat 0 of a new vector, and nothing from the discarded beats ever appears at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat strobe |
| in_data | input | W·DATA_W | W input words, lane j at bits [j·DATA_W +: DATA_W] |
| out_valid | output | 1 | Output beat strobe |
| out_data | output | W·DATA_W | W permuted words, lane j at bits [j·DATA_W +: DATA_W] |

## Verification
Each vector's results fall due at fixed offsets from the edge that samples its last input beat: output beat c is due two edges plus c after that edge. The driver records the cycle count when it presents a vector's last beat. It then pushes all W expected beats, each with its data and its due cycle, into a scoreboard queue. The monitor samples on the falling edge. Each `out_valid` beat must match both the data and the due cycle at the head of the queue. A head entry whose cycle passes without `out_valid` counts as a miss, and a beat that arrives with an empty queue counts as spurious.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

  // Address map used for one vector; consecutive vectors alternate.
  typedef enum logic {
    MAP_LINEAR = 1'b0,  // write at beat index, read at bank^beat
    MAP_SKEWED = 1'b1   // write at bank^beat, read at beat index
  } addr_map_e;

  function automatic addr_map_e other_map(input addr_map_e m);
    return (m == MAP_LINEAR) ? MAP_SKEWED : MAP_LINEAR;
  endfunction

endpackage

// File: rtl/tsp_bank_ram.sv
module tsp_bank_ram #(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // One write port, one registered read port; a read to the address being
  // written in the same cycle returns the old word.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tsp_xor_switch.sv
module tsp_xor_switch #(
  parameter int DW    = 16,
  parameter int LOG_W = 2
) (
  input  logic [(1<<LOG_W)*DW-1:0] din,
  input  logic [LOG_W-1:0]         sel,
  output logic [(1<<LOG_W)*DW-1:0] dout
);
  localparam int W = 1 << LOG_W;

  logic [DW-1:0] lane_in [W];

  for (genvar j = 0; j < W; j++) begin : g_unpack
    assign lane_in[j] = din[j*DW +: DW];
  end

  // Output lane j takes input lane j^sel: a permutation for any sel.
  for (genvar j = 0; j < W; j++) begin : g_lane
    assign dout[j*DW +: DW] = lane_in[sel ^ LOG_W'(j)];
  end

endmodule

// File: rtl/tsp_addr_ctrl.sv
module tsp_addr_ctrl import tsp_pkg::*; #(
  parameter int LOG_W = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic [LOG_W-1:0]            wr_sel,
  output logic [(1<<LOG_W)*LOG_W-1:0] wr_addr,
  output logic                        rd_en,
  output logic [LOG_W-1:0]            rd_sel,
  output logic [(1<<LOG_W)*LOG_W-1:0] rd_addr
);
  localparam int W = 1 << LOG_W;
  localparam logic [LOG_W-1:0] LAST = LOG_W'(W - 1);

  logic [LOG_W-1:0] wr_cnt;
  logic [LOG_W-1:0] rd_cnt;
  logic             rd_active;
  addr_map_e        wr_map;
  addr_map_e        rd_map;
  logic             vec_done;

  assign vec_done = in_valid && (wr_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt    <= '0;
      wr_map    <= MAP_LINEAR;
      rd_active <= 1'b0;
      rd_cnt    <= '0;
      rd_map    <= MAP_LINEAR;
    end else begin
      if (in_valid) begin
        wr_cnt <= wr_cnt + LOG_W'(1);
        if (wr_cnt == LAST) begin
          wr_map <= other_map(wr_map);
        end
      end
      if (vec_done) begin
        rd_active <= 1'b1;
        rd_cnt    <= '0;
        rd_map    <= wr_map;
      end else if (rd_active) begin
        rd_cnt <= rd_cnt + LOG_W'(1);
        if (rd_cnt == LAST) begin
          rd_active <= 1'b0;
        end
      end
    end
  end

  for (genvar k = 0; k < W; k++) begin : g_bank_addr
    assign wr_addr[k*LOG_W +: LOG_W] = (wr_map == MAP_LINEAR) ? wr_cnt
                                                               : (wr_cnt ^ LOG_W'(k));
    assign rd_addr[k*LOG_W +: LOG_W] = (rd_map == MAP_LINEAR) ? (rd_cnt ^ LOG_W'(k))
                                                               : rd_cnt;
  end

  assign wr_sel = wr_cnt;
  assign rd_sel = rd_cnt;
  assign rd_en  = rd_active;

  // A new vector may only complete once the previous read burst is on its last beat.
  AST_READ_DONE_BEFORE_REFILL: assert property (@(posedge clk) disable iff (rst)
    (vec_done && rd_active) |-> (rd_cnt == LAST))
    else $error("refill overtook read burst"); // R4

  AST_READ_STARTS_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
    vec_done |=> (rd_active && rd_cnt == '0))
    else $error("read burst did not start"); // R3

  AST_READ_BURST_STEPS: assert property (@(posedge clk) disable iff (rst)
    (rd_active && rd_cnt != LAST && !vec_done) |=> (rd_active && rd_cnt == LOG_W'($past(rd_cnt) + LOG_W'(1))))
    else $error("read burst broke early"); // R6

endmodule

// File: rtl/stream_transpose_perm.sv
module stream_transpose_perm #(
  parameter int DATA_W = 16,
  parameter int LOG_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  logic [(1<<LOG_W)*DATA_W-1:0]   in_data,
  output logic                           out_valid,
  output logic [(1<<LOG_W)*DATA_W-1:0]   out_data
);
  localparam int W     = 1 << LOG_W;
  localparam int BUS_W = W * DATA_W;

  logic [LOG_W-1:0]   wr_sel;
  logic [LOG_W-1:0]   rd_sel;
  logic [W*LOG_W-1:0] wr_addr;
  logic [W*LOG_W-1:0] rd_addr;
  logic               rd_en;
  logic [BUS_W-1:0]   wr_bus;
  logic [BUS_W-1:0]   rd_bus;
  logic [BUS_W-1:0]   out_bus;
  logic               s1_valid;
  logic [LOG_W-1:0]   s1_sel;

  tsp_addr_ctrl #(.LOG_W(LOG_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .wr_sel   (wr_sel),
    .wr_addr  (wr_addr),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .rd_addr  (rd_addr)
  );

  // Space: bank k receives input lane k^beat.
  tsp_xor_switch #(.DW(DATA_W), .LOG_W(LOG_W)) u_in_sw (
    .din  (in_data),
    .sel  (wr_sel),
    .dout (wr_bus)
  );

  // Time: one dual-port bank per lane.
  for (genvar k = 0; k < W; k++) begin : g_bank
    tsp_bank_ram #(.DW(DATA_W), .AW(LOG_W)) u_ram (
      .clk   (clk),
      .we    (in_valid),
      .waddr (wr_addr[k*LOG_W +: LOG_W]),
      .wdata (wr_bus[k*DATA_W +: DATA_W]),
      .raddr (rd_addr[k*LOG_W +: LOG_W]),
      .rdata (rd_bus[k*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_sel   <= '0;
    end else begin
      s1_valid <= rd_en;
      s1_sel   <= rd_sel;
    end
  end

  // Space again: output lane t takes bank t^beat.
  tsp_xor_switch #(.DW(DATA_W), .LOG_W(LOG_W)) u_out_sw (
    .din  (rd_bus),
    .sel  (s1_sel),
    .dout (out_bus)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_data <= out_bus;
      end
    end
  end

  AST_OUT_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ##1 out_valid)
    else $error("read beat produced no output"); // R3

  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(rd_en, 2))
    else $error("output without read"); // R6

endmodule

// File: tb/stream_transpose_perm_tb_top.sv
`timescale 1ns/1ps
module stream_transpose_perm_tb_top;
  localparam int LOG_W = 2;
  localparam int W     = 1 << LOG_W;
  localparam int DW    = 16;
  localparam int VW    = W * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [VW-1:0] in_data = '0;
  logic          out_valid;
  logic [VW-1:0] out_data;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  int n_vec = 0;
  bit done = 1'b0;

  logic [VW-1:0] exp_q[$];
  int            due_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stream_transpose_perm #(.DATA_W(DW), .LOG_W(LOG_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check_vec(input bit ok, input string req, input string what,
                           input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_int(input bit ok, input string req, input string what,
                           input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] junk();
    logic [VW-1:0] v;
    for (int j = 0; j < W; j++) v[j*DW +: DW] = DW'($urandom);
    return v;
  endfunction

  // Driver: called at a falling edge; returns at a falling edge.
  task automatic send_vector(input int gap_pct, input bit coded);
    logic [DW-1:0] wd [W][W];
    logic [VW-1:0] beat;
    for (int t = 0; t < W; t++)
      for (int p = 0; p < W; p++)
        wd[t][p] = coded ? DW'(t*W + p) : DW'($urandom);
    for (int t = 0; t < W; t++) begin
      while (gap_pct > 0 && ($urandom % 100) < gap_pct) begin
        in_valid = 1'b0;         // R5: idle beat with garbage data
        in_data  = junk();
        @(negedge clk);
      end
      for (int p = 0; p < W; p++) beat[p*DW +: DW] = wd[t][p];
      in_valid = 1'b1;
      in_data  = beat;
      if (t == W - 1) begin
        // R2 / R3: output beat c, lane t = input beat t, lane c, due 3+c falling edges on
        for (int c = 0; c < W; c++) begin
          logic [VW-1:0] e;
          for (int l = 0; l < W; l++) e[l*DW +: DW] = wd[l][c];
          exp_q.push_back(e);
          due_q.push_back(cyc + 3 + c);
        end
        n_vec++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) begin
      in_data = junk();
      @(negedge clk);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    idle(3);
  endtask

  // Monitor: scoreboard compare of data and due cycle.
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check_vec(1'b0, "R6", "out_valid with nothing pending", out_data, '0);
        end else begin
          logic [VW-1:0] e;
          int d;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          check_vec(out_data === e, "R2", "output beat data", out_data, e);
          check_int(cyc == d, "R3", "output beat cycle", cyc, d);
        end
      end else if (due_q.size() > 0 && due_q[0] <= cyc) begin
        check_int(1'b0, "R6", "expected output beat missing at cycle", cyc, due_q[0]);
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
      end
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    check_int(out_valid == 1'b0, "R1", "out_valid during reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check_int(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

    // R2: index-coded vector
    send_vector(0, 1'b1);
    drain();

    // R4: long back-to-back stream, both address maps many times
    for (int v = 0; v < 31; v++) send_vector(0, v % 7 == 0);
    drain();

    // R5: idle beats inside vectors
    for (int v = 0; v < 12; v++) send_vector(40, 1'b0);
    drain();

    // R5 / R6: idle gaps between vectors only
    for (int v = 0; v < 8; v++) begin
      send_vector(0, 1'b0);
      idle($urandom % 6);
    end
    drain();

    // R7: reset in the middle of a vector after an odd vector count
    send_vector(0, 1'b0);
    drain();
    in_valid = 1'b1; in_data = junk(); @(negedge clk);
    in_valid = 1'b1; in_data = junk(); @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < W + 3; k++) begin
      check_int(out_valid == 1'b0, "R7", "output from discarded beats", out_valid, 0);
      @(negedge clk);
    end
    send_vector(0, 1'b1);
    send_vector(0, 1'b0);
    send_vector(25, 1'b0);
    drain();

    check_int(exp_q.size() == 0, "R6", "pending beats at end", exp_q.size(), 0);
    done = 1'b1;
    report();
    $finish;
  end

endmodule